// File: doc/BRIEF.md
# Channel Command Register Bank

This block is the register file and interrupt logic for one channel of a command-list host adapter. Software places a command list in memory, programs its base address, and marks posted command slots in a 32-bit issue vector. A separate processing engine, which is not part of this block, reads that vector and fetches commands. It reports each finished slot on a completion strobe and each failure on an error strobe, and the block turns these reports into status bits and an interrupt.

Each register has its own write rule. Writes to the issue vector OR the data into the current value. Any write to the status register clears it. Writing zero to the run control register soft-resets the channel. The register port addresses 32-bit words inside a 4 KB channel window, so it takes a 10-bit word index. Reads are combinational on the word index.

Top module: `chan_regbank`

## Requirements
- R1: After a synchronous reset every register reads zero, and `run`, `irq`, `list_base` and `issue_vec` are zero.
- R2: A write to word 0 stores the data with bits 3:0 forced to zero. A write to word 1 stores the upper 32 bits. `list_base` is {word 1, word 0} from the cycle after the write.
- R3: A write to word 5 ORs the write data into the issue vector. Word 5 and `issue_vec` show the result.
- R4: A `done_valid` pulse clears issue bit `done_slot` and sets status bit 0 on the next clock edge.
- R5: When a software set and a hardware clear hit the same issue bit in one cycle, the bit ends up set.
- R6: An `err_valid` pulse sets status bit 30 and records `err_slot` in bits 28:24 and `err_buf` in bits 23:8. While bit 30 is already set, later errors leave these fields unchanged. Status bits 31, 29 and 7:1 read zero.
- R7: Any write to word 2 clears all status bits, whatever the data. A completion or error reported in the same cycle is still recorded.
- R8: Word 3 (interrupt enable) keeps only data bits 0 and 30. All other bits read zero.
- R9: `irq` is registered. It is 1 one cycle after (status bit 0 AND enable bit 0) OR (status bit 30 AND enable bit 30) holds, and 0 one cycle after that term is false.
- R10: A nonzero write to word 4 sets `run`, and word 4 then reads 1. A zero write clears run, the issue vector, the status and the enable, overriding hardware reports in the same cycle. The list base is left unchanged.
- R11: Word indices 6 to 1023 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 10 | Word index inside the 4 KB channel window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_waddr` (combinational) |
| done_valid | input | 1 | Engine reports a completed command |
| done_slot | input | 5 | Slot of the completed command |
| err_valid | input | 1 | Engine reports a failed command |
| err_slot | input | 5 | Slot of the failed command |
| err_buf | input | 16 | Buffer index of the failed transfer |
| run | output | 1 | Command-list polling enabled |
| list_base | output | 64 | Command-list base address |
| issue_vec | output | 32 | Posted-command bit vector |
| irq | output | 1 | Channel interrupt |

## Verification
The issue vector is first swept with single-bit OR writes into every slot and then with completions on every slot. This shows whether a write merges or replaces, and whether a clear reaches the right bit. Error reports are swept over all 32 slots with spread buffer indices, each followed by a second, different error. A wrong field position or a missing freeze on the second error shows up as a mismatch. Single-bit sweeps of the enable and of unused word indices separate stored bits from dropped ones. Same-cycle collisions (set against clear, status write against report, zero run write against completion) show which side of each priority rule the design takes.

// File: rtl/chan_reg_pkg.sv
package chan_reg_pkg;

    localparam int DATA_W = 32;
    localparam int SLOT_N = 32;
    localparam int SLOT_W = $clog2(SLOT_N);
    localparam int BUF_W  = 16;

    // word indices inside the channel window
    localparam int WI_LBLO  = 0;
    localparam int WI_LBHI  = 1;
    localparam int WI_STAT  = 2;
    localparam int WI_IEN   = 3;
    localparam int WI_RUN   = 4;
    localparam int WI_ISSUE = 5;

    // status layout (decoded by software)
    localparam int ST_DONE_BIT = 0;
    localparam int ST_BUF_LSB  = 8;
    localparam int ST_SLOT_LSB = 24;
    localparam int ST_ERR_BIT  = 30;

    localparam int LB_ALIGN_BITS = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LBLO,
        SEL_LBHI,
        SEL_STAT,
        SEL_IEN,
        SEL_RUN,
        SEL_ISSUE
    } reg_sel_e;

    typedef struct packed {
        logic lblo;
        logic lbhi;
        logic stat;
        logic ien;
        logic run_set;
        logic run_clr;
        logic issue;
    } wr_stb_t;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [BUF_W-1:0]  bufi;
    } fault_t;

    function automatic logic [DATA_W-1:0] pack_status(logic done_b, logic err_b, fault_t f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[ST_DONE_BIT] = done_b;
        w[ST_ERR_BIT]  = err_b;
        w[ST_SLOT_LSB +: SLOT_W] = f.slot;
        w[ST_BUF_LSB +: BUF_W]   = f.bufi;
        return w;
    endfunction

endpackage

// File: rtl/chan_addr_dec.sv
module chan_addr_dec
    import chan_reg_pkg::*;
#(
    parameter int WA_W = 10
) (
    input  logic            wr,
    input  logic [WA_W-1:0] waddr,
    input  logic            wdata_zero,
    output reg_sel_e        sel,
    output wr_stb_t         stb
);

    always_comb begin
        if      (waddr == WA_W'(WI_LBLO))  sel = SEL_LBLO;
        else if (waddr == WA_W'(WI_LBHI))  sel = SEL_LBHI;
        else if (waddr == WA_W'(WI_STAT))  sel = SEL_STAT;
        else if (waddr == WA_W'(WI_IEN))   sel = SEL_IEN;
        else if (waddr == WA_W'(WI_RUN))   sel = SEL_RUN;
        else if (waddr == WA_W'(WI_ISSUE)) sel = SEL_ISSUE;
        else                               sel = SEL_NONE;
    end

    always_comb begin
        stb         = '0;
        stb.lblo    = wr && (sel == SEL_LBLO);
        stb.lbhi    = wr && (sel == SEL_LBHI);
        stb.stat    = wr && (sel == SEL_STAT);
        stb.ien     = wr && (sel == SEL_IEN);
        stb.run_set = wr && (sel == SEL_RUN) && !wdata_zero;
        stb.run_clr = wr && (sel == SEL_RUN) && wdata_zero;
        stb.issue   = wr && (sel == SEL_ISSUE);
    end

endmodule

// File: rtl/chan_issue_vec.sv
module chan_issue_vec
    import chan_reg_pkg::*;
#(
    parameter int N   = SLOT_N,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_clr,
    input  logic          set_en,
    input  logic [N-1:0]  set_mask,
    input  logic          clr_en,
    input  logic [SW-1:0] clr_slot,
    output logic [N-1:0]  vec
);

    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || soft_clr)
                vec[i] <= 1'b0;
            else if (set_en && set_mask[i])
                vec[i] <= 1'b1;
            else if (clr_en && (clr_slot == SW'(i)))
                vec[i] <= 1'b0;
        end
    end

    // R3 R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set_en && !soft_clr) |=> ((vec & $past(set_mask)) == $past(set_mask)));

    // R4
    hw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !soft_clr && !(set_en && set_mask[clr_slot])) |=> !vec[$past(clr_slot)]);

    // R10
    soft_clr_chk: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (vec == '0));

endmodule

// File: rtl/chan_stat_irq.sv
module chan_stat_irq
    import chan_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_clr,
    input  logic              stat_wr,
    input  logic              ien_wr,
    input  logic              ien_done_d,
    input  logic              ien_err_d,
    input  logic              done_ev,
    input  logic              err_ev,
    input  fault_t            fault_in,
    output logic [DATA_W-1:0] stat_word,
    output logic [DATA_W-1:0] ien_word,
    output logic              irq
);

    logic   done_q;
    logic   err_q;
    fault_t fault_q;
    logic   en_done_q;
    logic   en_err_q;
    logic   irq_q;
    logic   irq_term;

    always_ff @(posedge clk) begin
        if (rst || soft_clr)
            done_q <= 1'b0;
        else if (done_ev)
            done_q <= 1'b1;
        else if (stat_wr)
            done_q <= 1'b0;
    end

    // first fault is kept until software clears status
    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            err_q   <= 1'b0;
            fault_q <= '0;
        end else if (err_ev && (!err_q || stat_wr)) begin
            err_q   <= 1'b1;
            fault_q <= fault_in;
        end else if (stat_wr) begin
            err_q   <= 1'b0;
            fault_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            en_done_q <= 1'b0;
            en_err_q  <= 1'b0;
        end else if (ien_wr) begin
            en_done_q <= ien_done_d;
            en_err_q  <= ien_err_d;
        end
    end

    assign irq_term = (done_q && en_done_q) || (err_q && en_err_q);

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= irq_term;
    end

    always_comb begin
        stat_word = pack_status(done_q, err_q, fault_q);
        ien_word  = '0;
        ien_word[ST_DONE_BIT] = en_done_q;
        ien_word[ST_ERR_BIT]  = en_err_q;
    end

    assign irq = irq_q;

    // R4
    done_set_chk: assert property (@(posedge clk) disable iff (rst)
        (done_ev && !soft_clr) |=> stat_word[ST_DONE_BIT]);

    // R6
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !stat_wr && !soft_clr) |=> (err_q && $stable(stat_word[ST_SLOT_LSB+SLOT_W-1:ST_BUF_LSB])));

    // R7
    stat_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !done_ev && !err_ev) |=> (stat_word == '0));

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ((stat_word[ST_DONE_BIT] && ien_word[ST_DONE_BIT]) ||
         (stat_word[ST_ERR_BIT] && ien_word[ST_ERR_BIT])) |=> irq);

    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !((stat_word[ST_DONE_BIT] && ien_word[ST_DONE_BIT]) ||
          (stat_word[ST_ERR_BIT] && ien_word[ST_ERR_BIT])) |=> !irq);

endmodule

// File: rtl/chan_regbank.sv
module chan_regbank
    import chan_reg_pkg::*;
#(
    parameter int WIN_BYTES = 4096,
    localparam int WA_W     = $clog2(WIN_BYTES) - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [WA_W-1:0]   reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              done_valid,
    input  logic [SLOT_W-1:0] done_slot,
    input  logic              err_valid,
    input  logic [SLOT_W-1:0] err_slot,
    input  logic [BUF_W-1:0]  err_buf,
    output logic              run,
    output logic [63:0]       list_base,
    output logic [SLOT_N-1:0] issue_vec,
    output logic              irq
);

    reg_sel_e          sel;
    wr_stb_t           stb;
    logic [DATA_W-1:0] lb_lo_q;
    logic [DATA_W-1:0] lb_hi_q;
    logic              run_q;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] ien_word;
    fault_t            fault_in;

    chan_addr_dec #(.WA_W(WA_W)) u_dec (
        .wr         (reg_wr),
        .waddr      (reg_waddr),
        .wdata_zero (reg_wdata == '0),
        .sel        (sel),
        .stb        (stb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lb_lo_q <= '0;
            lb_hi_q <= '0;
        end else begin
            if (stb.lblo)
                lb_lo_q <= {reg_wdata[DATA_W-1:LB_ALIGN_BITS], {LB_ALIGN_BITS{1'b0}}};
            if (stb.lbhi)
                lb_hi_q <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || stb.run_clr)
            run_q <= 1'b0;
        else if (stb.run_set)
            run_q <= 1'b1;
    end

    chan_issue_vec #(.N(SLOT_N)) u_issue (
        .clk      (clk),
        .rst      (rst),
        .soft_clr (stb.run_clr),
        .set_en   (stb.issue),
        .set_mask (reg_wdata[SLOT_N-1:0]),
        .clr_en   (done_valid),
        .clr_slot (done_slot),
        .vec      (issue_vec)
    );

    assign fault_in.slot = err_slot;
    assign fault_in.bufi = err_buf;

    chan_stat_irq u_stat (
        .clk        (clk),
        .rst        (rst),
        .soft_clr   (stb.run_clr),
        .stat_wr    (stb.stat),
        .ien_wr     (stb.ien),
        .ien_done_d (reg_wdata[ST_DONE_BIT]),
        .ien_err_d  (reg_wdata[ST_ERR_BIT]),
        .done_ev    (done_valid),
        .err_ev     (err_valid),
        .fault_in   (fault_in),
        .stat_word  (stat_word),
        .ien_word   (ien_word),
        .irq        (irq)
    );

    always_comb begin
        unique case (sel)
            SEL_LBLO:  reg_rdata = lb_lo_q;
            SEL_LBHI:  reg_rdata = lb_hi_q;
            SEL_STAT:  reg_rdata = stat_word;
            SEL_IEN:   reg_rdata = ien_word;
            SEL_RUN:   reg_rdata = {{(DATA_W-1){1'b0}}, run_q};
            SEL_ISSUE: reg_rdata = issue_vec;
            default:   reg_rdata = '0;
        endcase
    end

    assign run       = run_q;
    assign list_base = {lb_hi_q, lb_lo_q};

    // R2
    lbase_lo_chk: assert property (@(posedge clk) disable iff (rst)
        stb.lblo |=> (list_base[LB_ALIGN_BITS-1:0] == '0) &&
                     (list_base[DATA_W-1:LB_ALIGN_BITS] == $past(reg_wdata[DATA_W-1:LB_ALIGN_BITS])));

    // R10
    run_set_chk: assert property (@(posedge clk) disable iff (rst)
        stb.run_set |=> run);

    // R10
    run_clr_chk: assert property (@(posedge clk) disable iff (rst)
        stb.run_clr |=> (!run && stat_word == '0 && ien_word == '0));

    // R11
    unused_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && sel == SEL_NONE) |=> ($stable(list_base) && $stable(run) && $stable(ien_word)));

endmodule

// File: tb/sim_chan_regbank.sv
`timescale 1ns/1ps
module sim_chan_regbank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        done_valid = 1'b0;
    logic [4:0]  done_slot = '0;
    logic        err_valid = 1'b0;
    logic [4:0]  err_slot = '0;
    logic [15:0] err_buf = '0;
    logic        run;
    logic [63:0] list_base;
    logic [31:0] issue_vec;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    // model
    logic [31:0] m_lo, m_hi, m_issue, m_stat, m_en;

    always #2 clk = ~clk;

    chan_regbank u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .done_valid(done_valid), .done_slot(done_slot),
        .err_valid(err_valid), .err_slot(err_slot), .err_buf(err_buf),
        .run(run), .list_base(list_base), .issue_vec(issue_vec), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; done_valid = 1'b0; err_valid = 1'b0;
    endtask

    task automatic wr(input int wi, input logic [31:0] d);
        reg_wr = 1'b1; reg_waddr = 10'(wi); reg_wdata = d;
        tick();
    endtask

    task automatic rd(input int wi, output logic [31:0] d);
        reg_waddr = 10'(wi);
        #1 d = reg_rdata;
    endtask

    task automatic chk_rd(input string req, input int wi, input logic [31:0] exp);
        logic [31:0] d;
        rd(wi, d);
        chk(req, {32'h0, d}, {32'h0, exp});
    endtask

    task automatic chk_all(input string req);
        chk_rd(req, 0, m_lo);
        chk_rd(req, 1, m_hi);
        chk_rd(req, 2, m_stat);
        chk_rd(req, 3, m_en);
        chk_rd(req, 5, m_issue);
        chk(req, list_base, {m_hi, m_lo});
        chk(req, {32'h0, issue_vec}, {32'h0, m_issue});
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        if (!ended) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        m_lo = 0; m_hi = 0; m_issue = 0; m_stat = 0; m_en = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_all("R1");
        chk_rd("R1", 4, 0);
        chk("R1", {63'h0, run}, 0);
        chk("R1", {63'h0, irq}, 0);

        // R2 list base, alignment forced
        for (int k = 0; k < 32; k++) begin
            d = (32'hA5C3_96E7 << k) ^ 32'(k * 7);
            wr(0, d); m_lo = d & 32'hFFFF_FFF0;
            wr(1, ~d); m_hi = ~d;
            chk_rd("R2", 0, m_lo);
            chk("R2", list_base, {m_hi, m_lo});
        end

        // R3 OR-merge sweep
        for (int i = 0; i < 32; i++) begin
            wr(5, 32'h1 << i); m_issue |= 32'h1 << i;
            chk_rd("R3", 5, m_issue);
            chk("R3", {32'h0, issue_vec}, {32'h0, m_issue});
        end

        // R4 completion sweep
        for (int i = 0; i < 32; i++) begin
            done_valid = 1'b1; done_slot = 5'(i);
            tick();
            m_issue &= ~(32'h1 << i); m_stat = 32'h1;
            chk_rd("R4", 5, m_issue);
            chk_rd("R4", 2, m_stat);
        end

        // R7 clear ignores data
        wr(2, 32'h0); m_stat = 0;
        chk_rd("R7", 2, 0);
        done_valid = 1'b1; done_slot = 5'd3; tick();
        wr(2, 32'hFFFF_FFFF);
        chk_rd("R7", 2, 0);

        // R5 set beats clear
        wr(5, 32'h180); m_issue = 32'h180;
        reg_wr = 1'b1; reg_waddr = 10'd5; reg_wdata = 32'h80;
        done_valid = 1'b1; done_slot = 5'd7;
        tick(); m_stat = 32'h1;
        chk_rd("R5", 5, 32'h180);
        reg_wr = 1'b1; reg_waddr = 10'd5; reg_wdata = 32'h80;
        done_valid = 1'b1; done_slot = 5'd8;
        tick(); m_issue = 32'h80;
        chk_rd("R5", 5, m_issue);
        wr(2, 0); m_stat = 0;

        // R6 fault capture sweep
        for (int s = 0; s < 32; s++) begin
            logic [15:0] b;
            b = 16'((s * 2053 + 17) & 16'hFFFF);
            err_valid = 1'b1; err_slot = 5'(s); err_buf = b;
            tick();
            m_stat = (32'h1 << 30) | (32'(s) << 24) | (32'(b) << 8);
            chk_rd("R6", 2, m_stat);
            err_valid = 1'b1; err_slot = 5'(s ^ 31); err_buf = ~b;
            tick();
            chk_rd("R6", 2, m_stat);
            wr(2, 32'h1234_5678); m_stat = 0;
            chk_rd("R7", 2, 0);
        end

        // R7 report in same cycle as clear survives
        done_valid = 1'b1; done_slot = 5'd0; tick();
        reg_wr = 1'b1; reg_waddr = 10'd2; reg_wdata = 32'h0;
        done_valid = 1'b1; done_slot = 5'd1;
        tick();
        chk_rd("R7", 2, 32'h1);
        reg_wr = 1'b1; reg_waddr = 10'd2; reg_wdata = 32'h0;
        err_valid = 1'b1; err_slot = 5'd9; err_buf = 16'hBEEF;
        tick();
        chk_rd("R7", 2, (32'h1 << 30) | (32'd9 << 24) | (32'hBEEF << 8));
        wr(2, 0); m_stat = 0;

        // R8 enable bit sweep
        for (int b = 0; b < 32; b++) begin
            wr(3, 32'h1 << b);
            chk_rd("R8", 3, (b == 0 || b == 30) ? (32'h1 << b) : 32'h0);
        end
        wr(3, 32'hFFFF_FFFF);
        chk_rd("R8", 3, 32'h4000_0001);

        // R9 interrupt timing
        wr(3, 32'h1);
        done_valid = 1'b1; done_slot = 5'd2; tick();
        chk("R9", {63'h0, irq}, 0);
        tick();
        chk("R9", {63'h0, irq}, 1);
        wr(2, 0);
        chk("R9", {63'h0, irq}, 1);
        tick();
        chk("R9", {63'h0, irq}, 0);
        wr(3, 32'h4000_0000);
        done_valid = 1'b1; done_slot = 5'd2; tick();
        tick();
        chk("R9", {63'h0, irq}, 0);
        err_valid = 1'b1; err_slot = 5'd4; err_buf = 16'h1; tick();
        chk("R9", {63'h0, irq}, 0);
        tick();
        chk("R9", {63'h0, irq}, 1);
        wr(3, 0);
        tick();
        chk("R9", {63'h0, irq}, 0);
        wr(2, 0); m_stat = 0; m_en = 0;

        // R10 run control
        wr(4, 32'h0000_0500);
        chk("R10", {63'h0, run}, 1);
        chk_rd("R10", 4, 1);
        wr(5, 32'h00F0_000F);
        wr(3, 32'h4000_0001);
        done_valid = 1'b1; done_slot = 5'd0; tick();
        reg_wr = 1'b1; reg_waddr = 10'd4; reg_wdata = 32'h0;
        done_valid = 1'b1; done_slot = 5'd1;
        err_valid = 1'b1; err_slot = 5'd2; err_buf = 16'h7;
        tick();
        m_issue = 0; m_stat = 0; m_en = 0;
        chk("R10", {63'h0, run}, 0);
        chk_rd("R10", 4, 0);
        chk_all("R10");

        // R11 unused offsets
        wr(4, 32'h1);
        wr(3, 32'h1); m_en = 32'h1;
        wr(5, 32'h5); m_issue = 32'h5;
        wr(6, 32'hFFFF_FFFF);
        wr(512, 32'hFFFF_FFFF);
        wr(1023, 32'h0);
        chk_all("R11");
        chk("R11", {63'h0, run}, 1);
        for (int w = 6; w < 1024; w++) begin
            rd(w, d);
            if (w % 64 == 6 || w == 1023 || d !== 32'h0)
                chk("R11", {32'h0, d}, 64'h0);
        end

        ended = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule